// File: doc/BRIEF.md
# Joinable Transmit/Receive FIFO Pair Bank

This block gives every channel of an execution engine a pair of word queues. The transmit queue carries words that the host bus writes in toward the engine. The receive queue carries words that the engine produces back toward the host. Each channel has its own two join bits. These bits can merge the channel's storage into one queue of twice the base depth, running in either direction. The other direction is then disabled.

For every queue the host sees empty and full status bits, a packed fill-level word and a set of sticky debug flags. The flags record transmit overflow, receive underflow, transmit stall and receive stall, and each one is cleared by writing a one. Any change to a channel's join bits flushes both of that channel's queues. Toggling the receive join bit on and then off is therefore a way to empty a channel without changing its configuration.

All four traffic sources are single-cycle strobes: host push, host pop, engine pull and engine push. The head word of each queue is always presented combinationally, so a pop or pull strobe takes the word that is visible in the same cycle.

Top module: `fifo_pair_bank`

## Requirements
- R1: After reset, every queue is empty and not full, all level fields read 0, all debug flags read 0, and every channel reads back duplex mode (code 2'b00).
- R2: In duplex mode each queue holds DEPTH (4) words and returns them in the order written. The head word is shown on `h_rdata_o` / `e_rdata_o` in the channel's W-bit slice.
- R3: Channel n's transmit level sits at `level_o[n*8+3:n*8]` and its receive level at `level_o[n*8+7:n*8+4]`.
- R4: The status bits `tx_empty_o[n]`, `tx_full_o[n]`, `rx_empty_o[n]` and `rx_full_o[n]` describe channel n.
- R5: With join_tx=1 and join_rx=0 (mode code 2'b10 on `mode_o[2n+1:2n]`), the transmit queue holds 2*DEPTH words. The receive queue is disabled and reads as both empty and full, with level 0.
- R6: With join_rx=1 (mode code 2'b01), the receive queue holds 2*DEPTH words and the transmit queue is disabled in the same way. When both bits are set, the channel behaves as, and reads back as, receive-only.
- R7: A change of either join bit flushes both queues of that channel. Setting join_rx and clearing it again leaves empty queues and duplex mode.
- R8: A host push to a full transmit queue drops the word, leaves the level unchanged and sets transmit overflow at `dbg_o[n]`.
- R9: A host pop of an empty receive queue returns zero and sets receive underflow at `dbg_o[NCH+n]`.
- R10: An engine pull from an empty transmit queue sets transmit stall at `dbg_o[2*NCH+n]`. An engine push into a full receive queue drops the word and sets receive stall at `dbg_o[3*NCH+n]`.
- R11: A one in `dbg_clr_i` clears the flag at the same bit position at the next edge, and zero bits leave their flags alone. If a set event and a clear arrive in the same cycle, the set wins.
- R12: A push and a pop accepted in the same cycle on one queue leave its level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| join_rx_i | input | NCH | Per-channel receive join bit |
| join_tx_i | input | NCH | Per-channel transmit join bit |
| mode_o | output | 2*NCH | Decoded join mode per channel |
| h_push_i | input | NCH | Host push strobe into transmit queue |
| h_wdata_i | input | NCH*W | Host push words |
| h_pop_i | input | NCH | Host pop strobe from receive queue |
| h_rdata_o | output | NCH*W | Receive head words (zero when empty) |
| e_pull_i | input | NCH | Engine pull strobe from transmit queue |
| e_rdata_o | output | NCH*W | Transmit head words (zero when empty) |
| e_push_i | input | NCH | Engine push strobe into receive queue |
| e_wdata_i | input | NCH*W | Engine push words |
| tx_empty_o | output | NCH | Transmit queue empty |
| tx_full_o | output | NCH | Transmit queue full |
| rx_empty_o | output | NCH | Receive queue empty |
| rx_full_o | output | NCH | Receive queue full |
| level_o | output | NCH*8 | Packed fill levels |
| dbg_o | output | 4*NCH | Sticky debug flags |
| dbg_clr_i | input | 4*NCH | Write-one-to-clear for debug flags |

## Verification
The embedded properties take for granted that strobes are sampled only at rising edges and that the join bits are ordinary synchronous inputs. They do not assume that push or pop respects status, because overflow, underflow and stall are legal stimulus that the flags must record. The level-stability properties leave out the flush cycle, when capacity and count are briefly inconsistent. The directed tests therefore never change a join bit while a strobe is active, and each scenario waits at least one idle cycle after a mode change before it moves data.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
   typedef enum logic [1:0] {
      JM_DUPLEX  = 2'b00,
      JM_RX_ONLY = 2'b01,
      JM_TX_ONLY = 2'b10
   } join_mode_e;

   // receive join dominates: both bits set decodes as receive-only
   function automatic join_mode_e decode_join(input logic jrx, input logic jtx);
      if (jrx)      return JM_RX_ONLY;
      else if (jtx) return JM_TX_ONLY;
      else          return JM_DUPLEX;
   endfunction
endpackage

// File: rtl/fpb_join_ctl.sv
module fpb_join_ctl
   import fpb_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CAP_MAX = 2 * DEPTH,
   localparam int CW = $clog2(CAP_MAX + 1),
   localparam int PW = $clog2(CAP_MAX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          join_rx,
   input  logic          join_tx,
   output join_mode_e    mode,
   output logic          flush,
   output logic [CW-1:0] tx_cap,
   output logic [CW-1:0] rx_cap,
   output logic [PW-1:0] rx_base
);
   logic prev_rx, prev_tx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_rx <= 1'b0;
         prev_tx <= 1'b0;
      end else begin
         prev_rx <= join_rx;
         prev_tx <= join_tx;
      end
   end

   assign mode  = decode_join(join_rx, join_tx);
   assign flush = (prev_rx != join_rx) || (prev_tx != join_tx);

   always_comb begin
      unique case (mode)
         JM_RX_ONLY: begin
            tx_cap  = '0;
            rx_cap  = CW'(CAP_MAX);
            rx_base = '0;
         end
         JM_TX_ONLY: begin
            tx_cap  = CW'(CAP_MAX);
            rx_cap  = '0;
            rx_base = '0;
         end
         default: begin
            tx_cap  = CW'(DEPTH);
            rx_cap  = CW'(DEPTH);
            rx_base = PW'(DEPTH);
         end
      endcase
   end

   // R6
   mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(2'(mode)));

   // R5
   cap_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (CW+1)'(tx_cap) + (CW+1)'(rx_cap) == (CW+1)'(CAP_MAX));
endmodule

// File: rtl/fpb_ptrs.sv
module fpb_ptrs #(
   parameter int CAP_MAX = 8,
   localparam int CW = $clog2(CAP_MAX + 1),
   localparam int PW = $clog2(CAP_MAX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [CW-1:0] cap,
   input  logic          push,
   input  logic          pop,
   output logic          push_ok,
   output logic          pop_ok,
   output logic [PW-1:0] wr_ptr,
   output logic [PW-1:0] rd_ptr,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   logic [CW-1:0] last;

   assign last    = cap - 1'b1;
   assign empty   = (count == '0);
   assign full    = (count >= cap);
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic [CW-1:0] lim);
      return (CW'(p) == lim) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= step(wr_ptr, last);
         if (pop_ok)  rd_ptr <= step(rd_ptr, last);
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |-> count <= cap);

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop && !flush) |=> $stable(count));

   // R9
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !push && !flush) |=> count == '0);

   // R12
   balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && pop_ok) |=> $stable(count));

   // R7
   flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0 && empty));
endmodule

// File: rtl/fpb_sticky.sv
module fpb_sticky #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end

   // R11
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((q & $past(set)) == $past(set)));

   // R11
   sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr == '0) |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/fifo_pair_bank.sv
module fifo_pair_bank
   import fpb_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int DEPTH = 4,
   parameter int W     = 32,
   parameter int LVL_W = 4,
   localparam int STRIDE  = 2 * LVL_W,
   localparam int CAP_MAX = 2 * DEPTH,
   localparam int CW      = $clog2(CAP_MAX + 1),
   localparam int PW      = $clog2(CAP_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    join_rx_i,
   input  logic [NCH-1:0]    join_tx_i,
   output logic [2*NCH-1:0]  mode_o,
   input  logic [NCH-1:0]    h_push_i,
   input  logic [NCH*W-1:0]  h_wdata_i,
   input  logic [NCH-1:0]    h_pop_i,
   output logic [NCH*W-1:0]  h_rdata_o,
   input  logic [NCH-1:0]    e_pull_i,
   output logic [NCH*W-1:0]  e_rdata_o,
   input  logic [NCH-1:0]    e_push_i,
   input  logic [NCH*W-1:0]  e_wdata_i,
   output logic [NCH-1:0]    tx_empty_o,
   output logic [NCH-1:0]    tx_full_o,
   output logic [NCH-1:0]    rx_empty_o,
   output logic [NCH-1:0]    rx_full_o,
   output logic [NCH*STRIDE-1:0] level_o,
   output logic [4*NCH-1:0]  dbg_o,
   input  logic [4*NCH-1:0]  dbg_clr_i
);
   if (NCH < 1) begin : g_bad_nch
      $error("fifo_pair_bank: NCH must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("fifo_pair_bank: DEPTH must be at least 1");
   end
   if (CW > LVL_W) begin : g_bad_lvl
      $error("fifo_pair_bank: LVL_W too narrow for joined depth");
   end
   if (W < 1) begin : g_bad_w
      $error("fifo_pair_bank: W must be at least 1");
   end

   logic [4*NCH-1:0] dbg_set;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      join_mode_e    mode;
      logic          flush;
      logic [CW-1:0] tx_cap, rx_cap, tx_cnt, rx_cnt;
      logic [PW-1:0] rx_base, tx_wr, tx_rd, rx_wr, rx_rd, rx_wr_idx, rx_rd_idx;
      logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
      logic          tx_empty, tx_full, rx_empty, rx_full;
      logic [W-1:0]  mem [CAP_MAX];

      fpb_join_ctl #(.DEPTH(DEPTH)) u_join (
         .clk     (clk),
         .rst_n   (rst_n),
         .join_rx (join_rx_i[ch]),
         .join_tx (join_tx_i[ch]),
         .mode    (mode),
         .flush   (flush),
         .tx_cap  (tx_cap),
         .rx_cap  (rx_cap),
         .rx_base (rx_base)
      );

      fpb_ptrs #(.CAP_MAX(CAP_MAX)) u_tx (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush   (flush),
         .cap     (tx_cap),
         .push    (h_push_i[ch]),
         .pop     (e_pull_i[ch]),
         .push_ok (tx_push_ok),
         .pop_ok  (tx_pop_ok),
         .wr_ptr  (tx_wr),
         .rd_ptr  (tx_rd),
         .count   (tx_cnt),
         .empty   (tx_empty),
         .full    (tx_full)
      );

      fpb_ptrs #(.CAP_MAX(CAP_MAX)) u_rx (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush   (flush),
         .cap     (rx_cap),
         .push    (e_push_i[ch]),
         .pop     (h_pop_i[ch]),
         .push_ok (rx_push_ok),
         .pop_ok  (rx_pop_ok),
         .wr_ptr  (rx_wr),
         .rd_ptr  (rx_rd),
         .count   (rx_cnt),
         .empty   (rx_empty),
         .full    (rx_full)
      );

      // receive slots sit above the transmit half unless receive owns it all
      assign rx_wr_idx = rx_base + rx_wr;
      assign rx_rd_idx = rx_base + rx_rd;

      always_ff @(posedge clk) begin
         if (tx_push_ok) mem[tx_wr]     <= h_wdata_i[ch*W +: W];
         if (rx_push_ok) mem[rx_wr_idx] <= e_wdata_i[ch*W +: W];
      end

      assign e_rdata_o[ch*W +: W] = tx_empty ? '0 : mem[tx_rd];
      assign h_rdata_o[ch*W +: W] = rx_empty ? '0 : mem[rx_rd_idx];

      assign mode_o[2*ch +: 2]  = mode;
      assign tx_empty_o[ch]     = tx_empty;
      assign tx_full_o[ch]      = tx_full;
      assign rx_empty_o[ch]     = rx_empty;
      assign rx_full_o[ch]      = rx_full;
      assign level_o[ch*STRIDE +: LVL_W]         = LVL_W'(tx_cnt);
      assign level_o[ch*STRIDE + LVL_W +: LVL_W] = LVL_W'(rx_cnt);
      if (STRIDE > 2 * LVL_W) begin : g_pad
         assign level_o[ch*STRIDE + 2*LVL_W +: STRIDE - 2*LVL_W] = '0;
      end

      assign dbg_set[ch]         = h_push_i[ch] && tx_full;
      assign dbg_set[NCH+ch]     = h_pop_i[ch]  && rx_empty;
      assign dbg_set[2*NCH+ch]   = e_pull_i[ch] && tx_empty;
      assign dbg_set[3*NCH+ch]   = e_push_i[ch] && rx_full;

      // R3
      lvl_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tx_empty_o[ch] |-> level_o[ch*STRIDE +: LVL_W] == '0);

      // R9
      zero_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rx_empty_o[ch] |-> h_rdata_o[ch*W +: W] == '0);
   end

   fpb_sticky #(.N(4*NCH)) u_dbg (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (dbg_set),
      .clr   (dbg_clr_i),
      .q     (dbg_o)
   );
endmodule

// File: tb/tb_fifo_pair_bank.sv
`timescale 1ns/100ps
module tb_fifo_pair_bank;
   localparam int NCH = 4;
   localparam int W   = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0]   join_rx = '0, join_tx = '0;
   logic [2*NCH-1:0] mode;
   logic [NCH-1:0]   h_push = '0, h_pop = '0, e_pull = '0, e_push = '0;
   logic [NCH*W-1:0] h_wdata = '0, e_wdata = '0, h_rdata, e_rdata;
   logic [NCH-1:0]   tx_empty, tx_full, rx_empty, rx_full;
   logic [NCH*8-1:0] level;
   logic [4*NCH-1:0] dbg, dbg_clr = '0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   fifo_pair_bank #(.NCH(NCH), .DEPTH(4), .W(W), .LVL_W(4)) dut (
      .clk(clk), .rst_n(rst_n), .join_rx_i(join_rx), .join_tx_i(join_tx),
      .mode_o(mode), .h_push_i(h_push), .h_wdata_i(h_wdata), .h_pop_i(h_pop),
      .h_rdata_o(h_rdata), .e_pull_i(e_pull), .e_rdata_o(e_rdata),
      .e_push_i(e_push), .e_wdata_i(e_wdata), .tx_empty_o(tx_empty),
      .tx_full_o(tx_full), .rx_empty_o(rx_empty), .rx_full_o(rx_full),
      .level_o(level), .dbg_o(dbg), .dbg_clr_i(dbg_clr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hpush(input int ch, input logic [31:0] d);
      @(negedge clk);
      h_push[ch] = 1'b1;
      h_wdata[ch*W +: W] = d;
      @(negedge clk);
      h_push[ch] = 1'b0;
   endtask

   task automatic epush(input int ch, input logic [31:0] d);
      @(negedge clk);
      e_push[ch] = 1'b1;
      e_wdata[ch*W +: W] = d;
      @(negedge clk);
      e_push[ch] = 1'b0;
   endtask

   task automatic epull(input int ch, output logic [31:0] d);
      @(negedge clk);
      d = e_rdata[ch*W +: W];
      e_pull[ch] = 1'b1;
      @(negedge clk);
      e_pull[ch] = 1'b0;
   endtask

   task automatic hpop(input int ch, output logic [31:0] d);
      @(negedge clk);
      d = h_rdata[ch*W +: W];
      h_pop[ch] = 1'b1;
      @(negedge clk);
      h_pop[ch] = 1'b0;
   endtask

   task automatic clear_dbg(input logic [4*NCH-1:0] m);
      @(negedge clk);
      dbg_clr = m;
      @(negedge clk);
      dbg_clr = '0;
   endtask

   task automatic t_reset();
      chk("R1 tx_empty", 32'(tx_empty), 32'hF);
      chk("R1 rx_empty", 32'(rx_empty), 32'hF);
      chk("R1 full", 32'({tx_full, rx_full}), 32'h0);
      chk("R1 level", level, 32'h0);
      chk("R1 dbg", 32'(dbg), 32'h0);
      chk("R1 mode", 32'(mode), 32'h0);
   endtask

   task automatic t_duplex_tx();
      logic [31:0] d;
      for (int i = 0; i < 4; i++) hpush(1, 32'hA0 + i);
      chk("R3 tx level ch1", 32'(level[11:8]), 32'd4);
      chk("R3 rx level ch1", 32'(level[15:12]), 32'd0);
      chk("R4 tx_full ch1", 32'(tx_full), 32'h2);
      chk("R4 tx_empty", 32'(tx_empty), 32'hD);
      hpush(1, 32'hDEAD);
      chk("R8 overflow flag", 32'(dbg), 32'h0002);
      chk("R8 level kept", 32'(level[11:8]), 32'd4);
      for (int i = 0; i < 4; i++) begin
         epull(1, d);
         chk("R2 tx order", d, 32'hA0 + i);
      end
      epull(1, d);
      chk("R10 empty pull data", d, 32'h0);
      chk("R10 tx stall flag", 32'(dbg), 32'h0202);
      clear_dbg(16'h0202);
      chk("R11 w1c clear", 32'(dbg), 32'h0);
   endtask

   task automatic t_duplex_rx();
      logic [31:0] d;
      for (int i = 0; i < 4; i++) epush(2, 32'hB0 + i);
      chk("R3 rx level ch2", 32'(level[23:20]), 32'd4);
      chk("R4 rx_full ch2", 32'(rx_full), 32'h4);
      epush(2, 32'hBEEF);
      chk("R10 rx stall flag", 32'(dbg), 32'h4000);
      for (int i = 0; i < 4; i++) begin
         hpop(2, d);
         chk("R2 rx order", d, 32'hB0 + i);
      end
      hpop(2, d);
      chk("R9 underflow data", d, 32'h0);
      chk("R9 underflow flag", 32'(dbg), 32'h4040);
      clear_dbg(16'h4000);
      chk("R11 partial clear", 32'(dbg), 32'h0040);
      clear_dbg(16'h0040);
      chk("R11 clear rest", 32'(dbg), 32'h0);
   endtask

   task automatic t_txonly();
      logic [31:0] d;
      int bad = 0;
      @(negedge clk);
      join_tx[0] = 1'b1;
      @(negedge clk);
      chk("R5 mode code", 32'(mode[1:0]), 32'h2);
      chk("R5 rx disabled", 32'({rx_empty[0], rx_full[0]}), 32'h3);
      for (int i = 0; i < 8; i++) hpush(0, 32'hC0 + i);
      chk("R5 joined level", 32'(level[3:0]), 32'd8);
      chk("R5 joined full", 32'(tx_full[0]), 32'h1);
      for (int i = 0; i < 8; i++) begin
         epull(0, d);
         if (d !== 32'hC0 + i) bad++;
      end
      chk("R5 joined order mismatches", bad, 0);
      @(negedge clk);
      join_tx[0] = 1'b0;
      @(negedge clk);
      chk("R6 duplex code", 32'(mode[1:0]), 32'h0);
   endtask

   task automatic t_rxonly();
      logic [31:0] d;
      int bad = 0;
      @(negedge clk);
      join_rx[3] = 1'b1;
      @(negedge clk);
      chk("R6 mode code", 32'(mode[7:6]), 32'h1);
      chk("R6 tx disabled", 32'({tx_empty[3], tx_full[3]}), 32'h3);
      for (int i = 0; i < 8; i++) epush(3, 32'hF0 + i);
      chk("R6 joined level", 32'(level[31:28]), 32'd8);
      chk("R6 joined full", 32'(rx_full[3]), 32'h1);
      for (int i = 0; i < 3; i++) begin
         hpop(3, d);
         if (d !== 32'hF0 + i) bad++;
      end
      chk("R6 joined order mismatches", bad, 0);
      @(negedge clk);
      join_tx[3] = 1'b1;
      @(negedge clk);
      chk("R6 both bits read rx-only", 32'(mode[7:6]), 32'h1);
      chk("R7 join_tx change flush", 32'(level[31:28]), 32'd0);
      @(negedge clk);
      join_rx[3] = 1'b0;
      join_tx[3] = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_toggle();
      logic [31:0] d;
      hpush(1, 32'h11);
      hpush(1, 32'h22);
      chk("R3 level before toggle", 32'(level[11:8]), 32'd2);
      @(negedge clk);
      join_rx[1] = 1'b1;
      @(negedge clk);
      join_rx[1] = 1'b0;
      @(negedge clk);
      chk("R7 toggle flush level", 32'(level[11:8]), 32'd0);
      chk("R7 toggle mode kept", 32'(mode[3:2]), 32'h0);
      chk("R7 toggle empty", 32'(tx_empty[1]), 32'h1);
      hpush(1, 32'hD0);
      epull(1, d);
      chk("R7 usable after flush", d, 32'hD0);
   endtask

   task automatic t_simul();
      logic [31:0] d;
      hpush(1, 32'hE0);
      hpush(1, 32'hE1);
      @(negedge clk);
      d = e_rdata[1*W +: W];
      h_push[1] = 1'b1;
      h_wdata[1*W +: W] = 32'hE2;
      e_pull[1] = 1'b1;
      @(negedge clk);
      h_push[1] = 1'b0;
      e_pull[1] = 1'b0;
      chk("R12 head during overlap", d, 32'hE0);
      chk("R12 level unchanged", 32'(level[11:8]), 32'd2);
      epull(1, d);
      chk("R12 next word", d, 32'hE1);
      epull(1, d);
      chk("R12 pushed word", d, 32'hE2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_duplex_tx();
      t_duplex_rx();
      t_txonly();
      t_rxonly();
      t_toggle();
      t_simul();
      $display("%0d/%0d checks passed", checks - errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - errors, checks);
      $finish;
   end
endmodule